// File: doc/BRIEF.md
# Dual-Clock Occupancy Tracker with Delta Handshake

This block keeps count of how many entries a dual-clock FIFO holds. It does this without passing Gray-coded pointers between the clock domains. Each clock domain owns a local count that it updates at once for its own events: accepted writes on the producer side, accepted reads on the consumer side.

Each side sends its events to the other side as a message meaning "this many events since the previous message". The message travels over a toggle request/acknowledge pair, and each toggle passes through a multi-flop synchronizer. While a message is still unacknowledged, new events pile up in a local accumulator. The next message, sent once the acknowledge returns, carries the whole accumulated amount.

Because no event is ever sampled as a pulse across the boundary, none can be lost at any clock ratio. Because each side learns of the other's events late, the producer's count never reads low and the consumer's count never reads high. The producer therefore never overfills and the consumer never over-reads. The storage array and data path sit outside this block. They use `wr_ok` and `rd_ok` as their enables.

Top module: `xclk_occupancy`

## Requirements
- R1: While both resets are asserted and just after they release, `wr_level` and `rd_level` are 0, `wr_full` is 0 and `rd_empty` is 1.
- R2: `wr_ok` is 1 exactly when `wr_evt` is 1 and `wr_level` is below DEPTH. An accepted write adds one to `wr_level` at that `wclk` edge.
- R3: `wr_full` is 1 exactly when `wr_level` equals DEPTH. `wr_level` never exceeds DEPTH, and a write offered while full is dropped.
- R4: `rd_ok` is 1 exactly when `rd_evt` is 1 and `rd_level` is nonzero. `rd_empty` is 1 exactly when `rd_level` is 0, and a read offered while empty is dropped.
- R5: At every sampled cycle, `wr_level` is at least the true occupancy and `rd_level` is at most the true occupancy. True occupancy is accepted writes minus accepted reads.
- R6: Once both event inputs stay low, `wr_level` and `rd_level` both settle to the true occupancy within 40 cycles of each clock.
- R7: R5 and R6 hold for any ratio of the two clock frequencies, including a read clock ten times slower and one nearly four times faster than the write clock.
- R8: Each direction has at most one message in flight, and its delta value stays stable from request until acknowledge. A delivered delta is nonzero and at most DEPTH. Events that arrive while a message is outstanding are carried by the next message, so a burst of DEPTH back-to-back writes shows up in full as `rd_level` = DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Producer clock |
| wrst_n | input | 1 | Producer asynchronous reset, active low |
| wr_evt | input | 1 | Write request for this cycle |
| wr_ok | output | 1 | Write accepted (request and room available) |
| wr_full | output | 1 | Producer view of the FIFO is full |
| wr_level | output | $clog2(DEPTH+1) | Producer's conservative occupancy (never low) |
| rclk | input | 1 | Consumer clock |
| rrst_n | input | 1 | Consumer asynchronous reset, active low |
| rd_evt | input | 1 | Read request for this cycle |
| rd_ok | output | 1 | Read accepted (request and data available) |
| rd_empty | output | 1 | Consumer view of the FIFO is empty |
| rd_level | output | $clog2(DEPTH+1) | Consumer's conservative occupancy (never high) |

## Verification
A lost or duplicated delta shows up at the ports as a level that stays wrong forever. After traffic stops, the two levels stay apart from each other, or apart from the accepted-write minus accepted-read total, and the bench compares them within forty cycles of each clock. A delta applied with the wrong sign or too early shows up on the very next sampled cycle, as `wr_level` below the true occupancy or `rd_level` above it. An acceptance gate on the wrong comparison shows up in the same cycle as a mismatch on `wr_ok` or `rd_ok`. The bench sweeps several clock ratios and traffic mixes, then runs a saturating fill and a drain, so both boundaries and back-to-back accumulation are exercised.

// File: rtl/occ_pkg.sv
package occ_pkg;

  typedef enum logic {
    SIDE_WR = 1'b0,
    SIDE_RD = 1'b1
  } occ_side_e;

  // Next local count from the current count plus incoming and minus outgoing amounts.
  function automatic int unsigned occ_next(int unsigned cur, int unsigned up, int unsigned down);
    return cur + up - down;
  endfunction

  // Whether a local event may be accepted on the given side.
  function automatic logic occ_room(occ_side_e side, int unsigned cur, int unsigned depth);
    if (side == SIDE_WR) return cur < depth;
    return cur != 0;
  endfunction

endpackage

// File: rtl/occ_sync.sv
module occ_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/occ_delta_link.sv
module occ_delta_link #(
  parameter int DEPTH  = 16,
  parameter int STAGES = 2,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             s_clk,
  input  logic             s_rst_n,
  input  logic             s_event,
  input  logic             d_clk,
  input  logic             d_rst_n,
  output logic             d_valid,
  output logic [CNT_W-1:0] d_delta
);
  // Source domain: accumulate, launch, wait for the returning toggle.
  logic [CNT_W-1:0] pend_q;
  logic [CNT_W-1:0] hold_q;
  logic             req_q;
  logic             ack_s;
  logic             s_busy;
  logic             s_send;

  assign s_busy = req_q != ack_s;
  assign s_send = !s_busy && (pend_q != '0);

  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      pend_q <= '0;
      hold_q <= '0;
      req_q  <= 1'b0;
    end else begin
      if (s_send) begin
        hold_q <= pend_q;
        req_q  <= ~req_q;
        pend_q <= CNT_W'(s_event);
      end else begin
        pend_q <= pend_q + CNT_W'(s_event);
      end
    end
  end

  // Destination domain: detect the toggle, capture the held delta, echo back.
  logic req_d;
  logic seen_q;
  logic d_new;
  logic             valid_q;
  logic [CNT_W-1:0] delta_q;

  occ_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(d_clk), .rst_n(d_rst_n), .d(req_q), .q(req_d)
  );

  assign d_new = req_d != seen_q;

  always_ff @(posedge d_clk or negedge d_rst_n) begin
    if (!d_rst_n) begin
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
      delta_q <= '0;
    end else begin
      seen_q  <= req_d;
      valid_q <= d_new;
      delta_q <= d_new ? hold_q : '0;
    end
  end

  occ_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(s_clk), .rst_n(s_rst_n), .d(seen_q), .q(ack_s)
  );

  assign d_valid = valid_q;
  assign d_delta = delta_q;

  AST_HOLD_STABLE: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    s_busy |=> (!s_busy || $stable(hold_q))); // R8
  AST_PEND_BOUND: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    pend_q <= CNT_W'(DEPTH)); // R8
  AST_DELTA_NONZERO: assert property (@(posedge d_clk) disable iff (!d_rst_n)
    d_valid |-> (d_delta != '0 && d_delta <= CNT_W'(DEPTH))); // R8
endmodule

// File: rtl/occ_side.sv
module occ_side
  import occ_pkg::*;
#(
  parameter occ_side_e SIDE  = SIDE_WR,
  parameter int        DEPTH = 16,
  parameter int        CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             credit_vld,
  input  logic [CNT_W-1:0] credit,
  output logic             ok,
  output logic             flag,
  output logic [CNT_W-1:0] level
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] up;
  logic [CNT_W-1:0] down;
  logic             room;

  assign room = occ_room(SIDE, int'(cnt_q), DEPTH);
  assign ok   = evt && room;

  generate
    if (SIDE == SIDE_WR) begin : g_wr
      assign up   = CNT_W'(ok);
      assign down = credit_vld ? credit : '0;
      assign flag = cnt_q == CNT_W'(DEPTH);

      AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && evt) |=> cnt_q <= $past(cnt_q)); // R3
    end else begin : g_rd
      assign up   = credit_vld ? credit : '0;
      assign down = CNT_W'(ok);
      assign flag = cnt_q == '0;

      AST_EMPTY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && evt && !credit_vld) |=> cnt_q == '0); // R4
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CNT_W'(occ_next(int'(cnt_q), int'(up), int'(down)));
  end

  assign level = cnt_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R3
endmodule

// File: rtl/xclk_occupancy.sv
module xclk_occupancy
  import occ_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             wr_evt,
  output logic             wr_ok,
  output logic             wr_full,
  output logic [CNT_W-1:0] wr_level,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             rd_evt,
  output logic             rd_ok,
  output logic             rd_empty,
  output logic [CNT_W-1:0] rd_level
);
  logic             w2r_valid;
  logic [CNT_W-1:0] w2r_delta;
  logic             r2w_valid;
  logic [CNT_W-1:0] r2w_delta;

  occ_side #(.SIDE(SIDE_WR), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_wside (
    .clk(wclk), .rst_n(wrst_n), .evt(wr_evt),
    .credit_vld(r2w_valid), .credit(r2w_delta),
    .ok(wr_ok), .flag(wr_full), .level(wr_level)
  );

  occ_side #(.SIDE(SIDE_RD), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rside (
    .clk(rclk), .rst_n(rrst_n), .evt(rd_evt),
    .credit_vld(w2r_valid), .credit(w2r_delta),
    .ok(rd_ok), .flag(rd_empty), .level(rd_level)
  );

  occ_delta_link #(.DEPTH(DEPTH), .STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_w2r (
    .s_clk(wclk), .s_rst_n(wrst_n), .s_event(wr_ok),
    .d_clk(rclk), .d_rst_n(rrst_n), .d_valid(w2r_valid), .d_delta(w2r_delta)
  );

  occ_delta_link #(.DEPTH(DEPTH), .STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_r2w (
    .s_clk(rclk), .s_rst_n(rrst_n), .s_event(rd_ok),
    .d_clk(wclk), .d_rst_n(wrst_n), .d_valid(r2w_valid), .d_delta(r2w_delta)
  );

  AST_WR_OK_ROOM: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_ok |-> !wr_full); // R2
  AST_RD_OK_DATA: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_ok |-> !rd_empty); // R4
endmodule

// File: tb/tb_xclk_occupancy.sv
`timescale 1ns/1ps
module tb_xclk_occupancy;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic wr_evt = 0, rd_evt = 0;
  logic wr_ok, wr_full, rd_ok, rd_empty;
  logic [CW-1:0] wr_level, rd_level;

  real rhalf = 5.0;
  int  n_chk = 0, n_fail = 0;
  int  wacc = 0, racc = 0;
  bit  go = 0, run_wr = 0, run_rd = 0;
  int  wprob = 0, rprob = 0;

  xclk_occupancy #(.DEPTH(DEPTH), .SYNC_STAGES(2)) dut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_evt(wr_evt), .wr_ok(wr_ok),
    .wr_full(wr_full), .wr_level(wr_level),
    .rclk(rclk), .rrst_n(rrst_n), .rd_evt(rd_evt), .rd_ok(rd_ok),
    .rd_empty(rd_empty), .rd_level(rd_level)
  );

  always #5 wclk = ~wclk;
  initial forever #(rhalf) rclk = ~rclk;

  task automatic chk(bit good, string req, int act, int exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Producer-side driver and per-cycle checks.
  initial begin
    bit wexp_q = 0;
    forever begin
      @(posedge wclk); #1;
      if (go) begin
        if (wexp_q) wacc++;
        chk(int'(wr_level) >= wacc - racc, "R5 wr_level>=occ", int'(wr_level), wacc - racc);
        chk(wr_level <= CW'(DEPTH), "R3 wr_level bound", int'(wr_level), DEPTH);
        chk(wr_full == (wr_level == CW'(DEPTH)), "R3 wr_full", int'(wr_full), int'(wr_level == CW'(DEPTH)));
        wr_evt = run_wr && ($urandom_range(99) < wprob);
        wexp_q = wr_evt && (int'(wr_level) < DEPTH);
        #1;
        chk(wr_ok == wexp_q, "R2 wr_ok", int'(wr_ok), int'(wexp_q));
      end
    end
  end

  // Consumer-side driver and per-cycle checks.
  initial begin
    bit rexp_q = 0;
    forever begin
      @(posedge rclk); #0.2;
      if (go) begin
        if (rexp_q) racc++;
        chk(int'(rd_level) <= wacc - racc, "R5 rd_level<=occ", int'(rd_level), wacc - racc);
        chk(rd_empty == (rd_level == '0), "R4 rd_empty", int'(rd_empty), int'(rd_level == '0));
        rd_evt = run_rd && ($urandom_range(99) < rprob);
        rexp_q = rd_evt && (rd_level != '0);
        #0.2;
        chk(rd_ok == rexp_q, "R4 rd_ok", int'(rd_ok), int'(rexp_q));
      end
    end
  end

  task automatic quiesce(string req);
    run_wr = 0; run_rd = 0;
    repeat (40) @(posedge wclk);
    repeat (40) @(posedge rclk);
    @(negedge wclk);
    chk(int'(wr_level) == wacc - racc, {req, " wr_level settles"}, int'(wr_level), wacc - racc);
    chk(int'(rd_level) == wacc - racc, {req, " rd_level settles"}, int'(rd_level), wacc - racc);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all-reqs actual=%0d expected=%0d", 200000, 0);
    summary();
    $finish;
  end

  initial begin
    real ratios [5] = '{5.0, 3.5, 17.0, 50.0, 1.3};
    int  wmix   [4] = '{70, 30, 90, 50};
    int  rmix   [4] = '{30, 70, 90, 50};
    repeat (6) @(posedge wclk);
    @(negedge wclk);
    chk(wr_level == '0 && rd_level == '0, "R1 levels in reset", int'(wr_level) + int'(rd_level), 0);
    chk(!wr_full && rd_empty, "R1 flags in reset", int'({wr_full, rd_empty}), 1);
    wrst_n = 1; rrst_n = 1;
    repeat (3) @(posedge wclk);
    @(negedge wclk);
    chk(wr_level == '0 && !wr_full, "R1 wr after reset", int'(wr_level), 0);
    chk(rd_level == '0 && rd_empty, "R1 rd after reset", int'(rd_level), 0);
    go = 1;

    // Ratio x traffic-mix sweep (R7).
    for (int i = 0; i < 5; i++) begin
      rhalf = ratios[i];
      for (int j = 0; j < 4; j++) begin
        wprob = wmix[j]; rprob = rmix[j];
        run_wr = 1; run_rd = 1;
        repeat (300) @(posedge wclk);
        quiesce("R6 R7");
      end
    end

    // Saturating fill: back-to-back writes, no reads (R3, R8).
    rhalf = 5.0;
    wprob = 100; run_wr = 1;
    repeat (3 * DEPTH) @(posedge wclk);
    @(negedge wclk);
    chk(wr_full == 1'b1, "R3 full after fill", int'(wr_full), 1);
    quiesce("R6");
    chk(int'(rd_level) == DEPTH, "R8 burst delivered", int'(rd_level), DEPTH);

    // Drain with excess reads while empty (R4).
    rprob = 100; run_rd = 1;
    repeat (3 * DEPTH) @(posedge rclk);
    quiesce("R6");
    chk(rd_empty == 1'b1, "R4 empty after drain", int'(rd_empty), 1);
    chk(wr_level == '0 && !wr_full, "R4 producer sees drain", int'(wr_level), 0);

    summary();
    $finish;
  end
endmodule